// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a byte-wide I2C slave with 7-bit addressing in front of a small bank of 8-bit registers. It takes the SCL and SDA pad inputs, oversamples them on the system clock, removes short glitches, and drives an open-drain pull-down enable for SDA. A bus master first writes a register pointer. It can then write one data byte to that register, or read one byte back. The read can follow a repeated START in the same transaction, or come in a later transaction after a STOP.

The pointer is held across STOP conditions. A read that does not first set a pointer returns the register selected last. The pointer never moves by itself between accesses. The general call address and 10-bit address frames are never acknowledged. A pointer beyond the last register is still acknowledged, but it reads as zero and writes to it are dropped.

Top module: `i2c_regslave`

## Requirements
- R1: An address byte equal to {DEV_ADDR, R/W} is acknowledged: the slave pulls SDA low during the ninth clock of that byte, for both R/W = 0 and R/W = 1.
- R2: An address byte that does not match makes the slave leave SDA released for the rest of the transaction: no ACK, read bits read as 1, and no register is written, until the next START or STOP.
- R3: The general call address (first byte 0x00) and any byte that follows it are not acknowledged.
- R4: A 10-bit address prefix (first byte 11110xx plus R/W) is not acknowledged.
- R5: Direct write: START, {DEV_ADDR,0}, pointer, data, STOP. Each of the three bytes is acknowledged, and the register at the pointer then holds the data.
- R6: Combined read: START, {DEV_ADDR,0}, pointer, repeated START, {DEV_ADDR,1}. The slave then sends the register at the pointer MSB first, with a new bit after each SCL falling edge. It releases SDA for the master's acknowledge clock.
- R7: The pointer set by a pointer-only write survives a STOP. A later START, {DEV_ADDR,1} returns the register at that pointer.
- R8: The pointer never auto-increments. Repeated reads return the same register. A second data byte in a write is not acknowledged and changes no register.
- R9: A pointer at or above NUM_REGS is acknowledged. Writes through it change no register, and reads through it return 0x00.
- R10: A pulse on SCL or SDA shorter than FILT_CYC clock cycles is ignored. The default is 7 cycles, which is 56 ns at 125 MHz.
- R11: The slave changes SDA only while SCL is low. It samples incoming bits on the SCL rising edge.
- R12: Transfers work at both the 100 kbit/s and the 400 kbit/s SCL rate.
- R13: After reset, SDA is released, the pointer is 0, and register i holds (0x30 + 0x1D*i) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions take for granted a well-behaved master. It changes SDA only while SCL is low, except when it makes a START or STOP. It holds every real line level for longer than the filter window, so that start, stop and clock events never land on the same filtered cycle. The stimulus keeps each quarter bit period at 25 system clocks or more, well above the roughly ten cycles of synchronizer and filter delay. It limits injected glitches to 5 cycles. It never drives a START or STOP while the slave holds SDA low.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_IGN
  } eng_st_e;

  // Address frame hit: 7-bit match, reserved device codes never hit.
  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] dev);
    logic reserved;
    reserved = (dev == 7'h00) || (dev[6:2] == 5'b11110);
    return (frame[7:1] == dev) && !reserved;
  endfunction

  // Reset value of register idx.
  function automatic logic [7:0] rst_val(input int idx);
    return 8'(32'h30 + idx * 32'h1D);
  endfunction

endpackage

// File: rtl/i2c_rs_filter.sv
module i2c_rs_filter #(
  parameter int FILT_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic          out_q;
  logic [CW-1:0] cnt_q;
  logic          samp;

  assign samp = sync_q[1];
  assign filt = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      out_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (samp == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        out_q <= samp;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Checker: length of the current disagreement between sample and output.
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (samp != out_q) begin
      if (run_q != {CW{1'b1}}) run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  // R10
  glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> ($past(run_q) >= CW'(FILT_CYC - 1)));

endmodule

// File: rtl/i2c_rs_busev.sv
module i2c_rs_busev (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic scl_hi,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign scl_hi   = scl_f & scl_q;
  assign start_ev = scl_hi & sda_q & ~sda_f;
  assign stop_ev  = scl_hi & ~sda_q & sda_f;

endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              scl_hi,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_f,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ptr_q,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data
);
  eng_st_e           state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] sreg;
  logic [BYTE_W-1:0] txreg;
  logic              oe_q;
  logic              rw_q;

  logic byte_full;
  logic addr_decide;
  logic wr_fire;
  logic hit;

  assign byte_full   = (bit_cnt == 4'd8);
  assign addr_decide = (state == ST_ADDR) && scl_fall && byte_full;
  assign wr_fire     = (state == ST_WDAT) && scl_fall && byte_full;
  assign hit         = addr_hit(sreg, DEV_ADDR);

  assign sda_oe  = oe_q;
  assign wr_en   = wr_fire;
  assign wr_data = sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sreg    <= '0;
      txreg   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      ptr_q   <= '0;
    end else if (start_ev) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise && !byte_full) begin
            sreg    <= {sreg[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && byte_full) begin
            bit_cnt <= '0;
            case (state)
              ST_ADDR: begin
                if (hit) begin
                  oe_q  <= 1'b1;
                  rw_q  <= sreg[0];
                  state <= ST_AACK;
                end else begin
                  state <= ST_IGN;
                end
              end
              ST_PTR: begin
                oe_q  <= 1'b1;
                ptr_q <= sreg;
                state <= ST_PACK;
              end
              default: begin
                oe_q  <= 1'b1;
                state <= ST_WACK;
              end
            endcase
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              txreg <= rd_data;
              oe_q  <= ~rd_data[BYTE_W-1];
              state <= ST_RDAT;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_PTR;
            end
          end
        end
        ST_PACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_WDAT;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_IGN;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (byte_full) begin
              oe_q  <= 1'b0;
              state <= ST_IGN;
            end else begin
              txreg <= {txreg[BYTE_W-2:0], 1'b0};
              oe_q  <= ~txreg[BYTE_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R11
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hi |-> $stable(oe_q));

  // R2
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGN) |-> !oe_q);

  // R3
  gc_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_decide && (sreg[7:1] == 7'h00)) |=> !oe_q);

  // R4
  tenbit_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_decide && (sreg[7:3] == 5'b11110)) |=> !oe_q);

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> ($past(state) == ST_PTR));

endmodule

// File: rtl/i2c_rs_regfile.sv
module i2c_rs_regfile
  import i2c_rs_pkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_ptr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_ptr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;
  logic wr_ok;

  assign wr_ok = (wr_ptr < BYTE_W'(NUM_REGS));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= rst_val(g);
      end else if (wr_en && wr_ok && (wr_ptr == BYTE_W'(g))) begin
        regs_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_ptr == BYTE_W'(i)) rd_data = regs_q[i];
    end
  end

  // R9
  oor_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> $stable(regs_q));

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NUM_REGS = 9,
  parameter int         FILT_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic [1:0] raw_lines;
  logic [1:0] filt_lines;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_rs_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[g]),
      .filt (filt_lines[g])
    );
  end

  logic scl_rise, scl_fall, scl_hi, start_ev, stop_ev;

  i2c_rs_busev u_busev (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (filt_lines[0]),
    .sda_f   (filt_lines[1]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .scl_hi  (scl_hi),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  logic [BYTE_W-1:0] ptr_q, rd_data, wr_data;
  logic              wr_en;

  i2c_rs_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .scl_hi  (scl_hi),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .sda_f   (filt_lines[1]),
    .rd_data (rd_data),
    .sda_oe  (sda_oe),
    .ptr_q   (ptr_q),
    .wr_en   (wr_en),
    .wr_data (wr_data)
  );

  i2c_rs_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_ptr (ptr_q),
    .wr_data(wr_data),
    .rd_ptr (ptr_q),
    .rd_data(rd_data)
  );

endmodule

// File: tb/i2c_regslave_tb_top.sv
`timescale 1ns/1ps
module i2c_regslave_tb_top;
  localparam logic [6:0] DEV  = 7'h2A;
  localparam logic [6:0] BAD  = 7'h2B;
  localparam int         NREG = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic scl_gl = 1'b0;
  logic sda_gl = 1'b0;
  logic glitch_on = 1'b0;
  logic done = 1'b0;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int q = 25;
  int n_chk = 0;
  int n_err = 0;
  int r11_viol = 0;
  logic [7:0] mdl [NREG];

  always #4 clk = ~clk;

  i2c_regslave #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .FILT_CYC(7)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl ^ scl_gl), .sda_i(sda_line ^ sda_gl), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] rv(input int i);
    return 8'((48 + 29 * i) % 256);
  endfunction

  function automatic logic [7:0] exp_rd(input int p);
    return (p < NREG) ? mdl[p] : 8'h00;
  endfunction

  // R11 monitor: slave enable must not move while SCL is held high
  logic scl_prev = 1'b1;
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_n && scl && scl_prev && (sda_oe != oe_prev)) r11_viol++;
    scl_prev <= scl;
    oe_prev  <= sda_oe;
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic r);
    wait_n(q);
    m_sda = b;
    if (glitch_on) begin
      wait_n(3); scl_gl = 1'b1; wait_n(5); scl_gl = 1'b0;
    end
    wait_n(q);
    scl = 1'b1;
    wait_n(q);
    r = sda_line;
    if (glitch_on) begin
      sda_gl = 1'b1; wait_n(5); sda_gl = 1'b0;
    end
    wait_n(q);
    scl = 1'b0;
  endtask

  task automatic bus_start();
    wait_n(q); m_sda = 1'b1;
    wait_n(q); scl = 1'b1;
    wait_n(q); m_sda = 1'b0;
    wait_n(q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_n(q); m_sda = 1'b0;
    wait_n(q); scl = 1'b1;
    wait_n(q); m_sda = 1'b1;
    wait_n(q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) send_bit(b[i], r);
    send_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, r);
      d[i] = r;
    end
    send_bit(~mack, r);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({a, 1'b0}, acks[2]);
    send_byte(p, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic do_setptr(input logic [6:0] a, input logic [7:0] p, output logic [1:0] acks);
    bus_start();
    send_byte({a, 1'b0}, acks[1]);
    send_byte(p, acks[0]);
    bus_stop();
  endtask

  task automatic do_read_comb(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({a, 1'b0}, acks[2]);
    send_byte(p, acks[1]);
    bus_start();
    send_byte({a, 1'b1}, acks[0]);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic do_read_cur(input logic [6:0] a, output logic [7:0] d, output logic ack);
    bus_start();
    send_byte({a, 1'b1}, ack);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [7:0] d;
    logic [2:0] a3;
    logic [1:0] a2;
    logic       a1;
    logic [7:0] p, p2;

    void'($urandom(32'd4711));
    for (int i = 0; i < NREG; i++) mdl[i] = rv(i);

    wait_n(10);
    rst_n = 1'b1;
    wait_n(20);

    // R13: reset state, pointer 0
    chk("R13", "sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    do_read_cur(DEV, d, a1);
    chk("R1", "read address ack", {7'd0, a1}, 8'h01);
    chk("R13", "reset value of reg 0", d, mdl[0]);

    // R5 / R6: direct write then combined read
    do_write(DEV, 8'd3, 8'hA5, a3);
    mdl[3] = 8'hA5;
    chk("R5", "write acks", {5'd0, a3}, 8'h07);
    do_read_comb(DEV, 8'd3, d, a3);
    chk("R6", "combined read acks", {5'd0, a3}, 8'h07);
    chk("R6", "combined read data", d, mdl[3]);

    // R7 / R8: pointer across STOP, no auto-increment
    do_setptr(DEV, 8'd7, a2);
    chk("R7", "pointer write acks", {6'd0, a2}, 8'h03);
    do_read_cur(DEV, d, a1);
    chk("R7", "stop-separated read", d, mdl[7]);
    do_read_cur(DEV, d, a1);
    chk("R8", "second read same register", d, mdl[7]);

    // R8: extra data byte is refused
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    send_byte(8'd4, a1);
    send_byte(8'h3C, a1);
    chk("R5", "first data byte ack", {7'd0, a1}, 8'h01);
    send_byte(8'hC3, a1);
    chk("R8", "second data byte nack", {7'd0, a1}, 8'h00);
    bus_stop();
    mdl[4] = 8'h3C;
    do_read_comb(DEV, 8'd5, d, a3);
    chk("R8", "neighbour reg 5 untouched", d, mdl[5]);
    do_read_comb(DEV, 8'd4, d, a3);
    chk("R5", "reg 4 holds first byte", d, mdl[4]);

    // R2: address mismatch
    do_write(BAD, 8'd2, 8'h55, a3);
    chk("R2", "mismatch write acks", {5'd0, a3}, 8'h00);
    bus_start();
    send_byte({BAD, 1'b1}, a1);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R2", "mismatch read ack", {7'd0, a1}, 8'h00);
    chk("R2", "mismatch read bits released", d, 8'hFF);
    do_read_comb(DEV, 8'd2, d, a3);
    chk("R2", "reg 2 untouched", d, mdl[2]);

    // R3: general call
    bus_start();
    send_byte(8'h00, a1);
    chk("R3", "general call nack", {7'd0, a1}, 8'h00);
    send_byte(8'h06, a1);
    chk("R3", "general call data nack", {7'd0, a1}, 8'h00);
    bus_stop();

    // R4: 10-bit prefix
    bus_start();
    send_byte(8'hF4, a1);
    chk("R4", "10-bit prefix nack", {7'd0, a1}, 8'h00);
    send_byte({1'b0, DEV}, a1);
    chk("R4", "10-bit second byte nack", {7'd0, a1}, 8'h00);
    bus_stop();

    // R9: out-of-range pointer
    do_write(DEV, 8'(NREG + 3), 8'h77, a3);
    chk("R9", "out-of-range write acks", {5'd0, a3}, 8'h07);
    do_read_comb(DEV, 8'(NREG + 3), d, a3);
    chk("R9", "out-of-range read zero", d, 8'h00);
    do_read_comb(DEV, 8'hFF, d, a3);
    chk("R9", "pointer 0xFF read zero", d, 8'h00);
    do_read_comb(DEV, 8'(NREG - 1), d, a3);
    chk("R9", "last register untouched", d, mdl[NREG-1]);

    // R10: glitches on both lines
    glitch_on = 1'b1;
    do_write(DEV, 8'd1, 8'h5A, a3);
    mdl[1] = 8'h5A;
    chk("R10", "write acks under glitches", {5'd0, a3}, 8'h07);
    do_read_comb(DEV, 8'd1, d, a3);
    chk("R10", "read under glitches", d, mdl[1]);
    glitch_on = 1'b0;

    // R12: 400 kbit/s and 100 kbit/s timing
    q = 78;
    do_read_comb(DEV, 8'd3, d, a3);
    chk("R12", "400k combined read", d, mdl[3]);
    q = 312;
    do_read_cur(DEV, d, a1);
    chk("R12", "100k stop-separated read", d, mdl[3]);
    q = 25;

    // Random writes and pointer reads
    for (int it = 0; it < 6; it++) begin
      p = 8'($urandom_range(0, NREG + 1));
      d = 8'($urandom);
      do_write(DEV, p, d, a3);
      if (p < NREG) mdl[p] = d;
      chk("R5", "random write acks", {5'd0, a3}, 8'h07);
      p2 = 8'($urandom_range(0, NREG + 1));
      do_setptr(DEV, p2, a2);
      do_read_cur(DEV, d, a1);
      chk("R7", "random pointer read", d, exp_rd(int'(p2)));
    end

    chk("R11", "SDA moves while SCL high", 8'(r11_viol), 8'h00);

    done = 1'b1;
    finish_up();
  end

endmodule